// File: doc/BRIEF.md
# Byte-Loaded DAC Code Register

This block is the digital front end of a 12-bit digital-to-analog converter whose host port is only eight bits wide. A write strobe, two byte-select strobes and a load-DAC strobe, all active low, are decoded on each write. Depending on their levels, a write fills the upper or lower part of a 12-bit staging register, moves the staging register into the DAC register, or does both in one go. A normal update therefore costs three writes: upper byte, lower byte, then a load-only write. Fewer writes are needed when the load strobe rides along with a byte write.

The write strobe is asynchronous to the block clock, so it passes through a synchroniser first. A write acts once, in the clock cycle after its synchronised falling edge is seen. The selects, the load strobe and the data bus are sampled in that cycle. A format/override input and a control input set how the two bytes pack into 12 bits. When the format/override input is low, they instead force the converter code to all zeros or all ones. The stored DAC register is left untouched while the code is forced.

Top module: `byte_dac_ctrl`

## Requirements
- R1: After reset the staging register, the DAC register and the packing mode (left-justified) are cleared, so `dacCode` reads 0x000 with `fmtOvrN` high.
- R2: While `wrN` stays high, no register changes, whatever `msbSelN`, `lsbSelN`, `loadN` and `busData` do.
- R3: A write with `lsbSelN` low, `msbSelN` high and `loadN` high updates only the low part of the staging register. `dacCode` keeps its value.
- R4: A write with `lsbSelN` low, `msbSelN` high and `loadN` low updates the low part of the staging register and moves the updated 12-bit value to the DAC register in the same write.
- R5: A write with `msbSelN` low and `lsbSelN` high updates the high part of the staging register. If `loadN` is also low, the updated value moves to the DAC register in the same write.
- R6: A write with both selects high and `loadN` low copies the staging register to the DAC register and takes nothing from the bus.
- R7: A write with both selects low changes neither register, even with `loadN` low.
- R8: In left-justified mode (`fmtOvrN` high, `ctrlSel` 0), the high byte fills bits 11..4 and bits 7..4 of the low byte fill bits 3..0.
- R9: In right-justified mode (`fmtOvrN` high, `ctrlSel` 1), bits 3..0 of the high byte fill bits 11..8 and the low byte fills bits 7..0.
- R10: With `fmtOvrN` low, `dacCode` is 0x000 when `ctrlSel` is 0 and 0xFFF when `ctrlSel` is 1.
- R11: Releasing the override brings back the DAC register contents unchanged on `dacCode`.
- R12: Writes made while the override is active still update both registers. They use the packing mode last selected while `fmtOvrN` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busData | input | 8 | Host data byte |
| wrN | input | 1 | Active-low write strobe, asynchronous |
| msbSelN | input | 1 | Active-low high-byte select |
| lsbSelN | input | 1 | Active-low low-byte select |
| loadN | input | 1 | Active-low load-DAC strobe |
| fmtOvrN | input | 1 | High: `ctrlSel` picks the packing mode; low: `ctrlSel` picks the forced code |
| ctrlSel | input | 1 | Packing mode or forced-code select |
| dacCode | output | 12 | Code presented to the converter |

## Verification
The bench builds the block with its default parameters: a 12-bit code, an 8-bit bus and a two-stage write synchroniser. With these values the two packing layouts overlap in four bits. Choosing a high byte whose two nibbles differ therefore separates left from right packing in a single value. The bench also uses a write made during an override to show that the packing mode is held, not taken from `ctrlSel`, while the code is forced.

// File: rtl/byte_dac_pkg.sv
package byte_dac_pkg;
  typedef struct packed {
    logic loadHigh;
    logic loadLow;
    logic xfer;
  } dacStrobe_t;
endpackage

// File: rtl/byte_dac_decode.sv
module byte_dac_decode
  import byte_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrN,
  input  logic       msbSelN,
  input  logic       lsbSelN,
  input  logic       loadN,
  output dacStrobe_t strobe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] wrSync;
  logic         wrPrev;
  logic         wrFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSync <= '1;
      wrPrev <= 1'b1;
    end else begin
      wrSync <= {wrSync[TOP-1:0], wrN};
      wrPrev <= wrSync[TOP];
    end
  end

  assign wrFall = wrPrev & ~wrSync[TOP];

  always_comb begin
    strobe = '0;
    if (wrFall) begin
      unique case ({msbSelN, lsbSelN})
        2'b10: begin strobe.loadLow  = 1'b1; strobe.xfer = ~loadN; end
        2'b01: begin strobe.loadHigh = 1'b1; strobe.xfer = ~loadN; end
        2'b11: strobe.xfer = ~loadN;
        default: strobe = '0;
      endcase
    end
  end

  assert_quiet_when_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrSync[TOP] |-> (strobe == '0));
  assert_one_byte_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadHigh, strobe.loadLow}));
  assert_single_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe != '0) |=> (strobe == '0));
endmodule

// File: rtl/byte_dac_path.sv
module byte_dac_path
  import byte_dac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobe_t        strobe,
  input  logic [BUS_W-1:0]  busData,
  input  logic              fmtOvrN,
  input  logic              ctrlSel,
  output logic [CODE_W-1:0] dacCode
);
  localparam int REM_W = CODE_W - BUS_W;

  logic [CODE_W-1:0] stageReg;
  logic [CODE_W-1:0] stageNext;
  logic [CODE_W-1:0] dacReg;
  logic              rightMode;

  always_comb begin
    stageNext = stageReg;
    if (!rightMode) begin
      if (strobe.loadHigh) stageNext[CODE_W-1 -: BUS_W] = busData;
      if (strobe.loadLow)  stageNext[REM_W-1:0] = busData[BUS_W-1 -: REM_W];
    end else begin
      if (strobe.loadHigh) stageNext[CODE_W-1:BUS_W] = busData[REM_W-1:0];
      if (strobe.loadLow)  stageNext[BUS_W-1:0] = busData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageReg  <= '0;
      dacReg    <= '0;
      rightMode <= 1'b0;
    end else begin
      stageReg <= stageNext;
      if (strobe.xfer) dacReg <= stageNext;
      if (fmtOvrN) rightMode <= ctrlSel;
    end
  end

  always_comb begin
    if (fmtOvrN) dacCode = dacReg;
    else         dacCode = ctrlSel ? '1 : '0;
  end

  assert_dac_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xfer |=> $stable(dacReg));
  assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadHigh || strobe.loadLow) |=> $stable(stageReg));
  assert_force_code_R10: assert property (@(posedge clk) disable iff (!rstN)
    !fmtOvrN |-> (dacCode == (ctrlSel ? {CODE_W{1'b1}} : {CODE_W{1'b0}})));
  assert_mode_held_R12: assert property (@(posedge clk) disable iff (!rstN)
    !fmtOvrN |=> $stable(rightMode));
endmodule

// File: rtl/byte_dac_ctrl.sv
module byte_dac_ctrl
  import byte_dac_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  busData,
  input  logic              wrN,
  input  logic              msbSelN,
  input  logic              lsbSelN,
  input  logic              loadN,
  input  logic              fmtOvrN,
  input  logic              ctrlSel,
  output logic [CODE_W-1:0] dacCode
);
  dacStrobe_t strobe;

  byte_dac_decode #(.SYNC_STAGES(SYNC_STAGES)) decode_i (
    .clk(clk), .rstN(rstN), .wrN(wrN), .msbSelN(msbSelN),
    .lsbSelN(lsbSelN), .loadN(loadN), .strobe(strobe)
  );

  byte_dac_path #(.CODE_W(CODE_W), .BUS_W(BUS_W)) path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busData(busData),
    .fmtOvrN(fmtOvrN), .ctrlSel(ctrlSel), .dacCode(dacCode)
  );
endmodule

// File: tb/byte_dac_ctrl_tb.sv
module byte_dac_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busData = '0;
  logic        wrN = 1'b1, msbSelN = 1'b1, lsbSelN = 1'b1, loadN = 1'b1;
  logic        fmtOvrN = 1'b1, ctrlSel = 1'b0;
  logic [11:0] dacCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [11:0] code;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  byte_dac_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busData(busData), .wrN(wrN),
    .msbSelN(msbSelN), .lsbSelN(lsbSelN), .loadN(loadN),
    .fmtOvrN(fmtOvrN), .ctrlSel(ctrlSel), .dacCode(dacCode)
  );

  // Monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (dacCode !== it.code) begin
          errors++;
          $display("FAIL %s: dacCode=%03h expected=%03h", it.tag, dacCode, it.code);
        end
      end
    end
  end

  task automatic expect_code(input logic [11:0] code, input string tag);
    expQ.push_back('{code, tag});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic mN, input logic lN, input logic ldN,
                           input logic [7:0] d);
    @(negedge clk);
    busData = d; msbSelN = mN; lsbSelN = lN; loadN = ldN;
    @(negedge clk);
    wrN = 1'b0;
    repeat (5) @(negedge clk);
    wrN = 1'b1;
    repeat (5) @(negedge clk);
    msbSelN = 1'b1; lsbSelN = 1'b1; loadN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    expect_code(12'h000, "R1 reset");

    // R2: strobes move while write stays high
    msbSelN = 1'b0; loadN = 1'b0; busData = 8'hFF;
    repeat (4) @(negedge clk);
    lsbSelN = 1'b0; msbSelN = 1'b1;
    repeat (4) @(negedge clk);
    msbSelN = 1'b1; lsbSelN = 1'b1; loadN = 1'b1;
    repeat (6) @(negedge clk);
    expect_code(12'h000, "R2 write high idle");
    bus_write(1, 1, 0, 8'h00);
    expect_code(12'h000, "R2 staging untouched");

    // left-justified mode
    bus_write(0, 1, 1, 8'hAB);
    expect_code(12'h000, "R5 high byte no load");
    bus_write(1, 0, 1, 8'hCD);
    expect_code(12'h000, "R3 low byte no load");
    bus_write(1, 1, 0, 8'h00);
    expect_code(12'hABC, "R6 R8 load only");
    bus_write(1, 0, 0, 8'h52);
    expect_code(12'hAB5, "R4 R8 low byte with load");
    bus_write(0, 1, 0, 8'h12);
    expect_code(12'h125, "R5 high byte with load");
    bus_write(0, 0, 0, 8'hFF);
    expect_code(12'h125, "R7 both selects low");
    bus_write(1, 1, 0, 8'h99);
    expect_code(12'h125, "R7 staging unchanged");

    // right-justified mode
    ctrlSel = 1'b1;
    repeat (2) @(negedge clk);
    bus_write(0, 1, 1, 8'h3E);
    expect_code(12'h125, "R9 high byte no load");
    bus_write(1, 0, 0, 8'h77);
    expect_code(12'hE77, "R9 right packing");

    // override
    ctrlSel = 1'b0; fmtOvrN = 1'b0;
    repeat (2) @(negedge clk);
    expect_code(12'h000, "R10 force zeros");
    ctrlSel = 1'b1;
    repeat (2) @(negedge clk);
    expect_code(12'hFFF, "R10 force ones");
    fmtOvrN = 1'b1;
    repeat (2) @(negedge clk);
    expect_code(12'hE77, "R11 stored value back");

    // R12: switch to left selection under override; mode stays right
    fmtOvrN = 1'b0; ctrlSel = 1'b0;
    repeat (2) @(negedge clk);
    bus_write(0, 1, 0, 8'h4A);
    expect_code(12'h000, "R10 R12 forced during write");
    ctrlSel = 1'b1;
    repeat (2) @(negedge clk);
    fmtOvrN = 1'b1;
    repeat (2) @(negedge clk);
    expect_code(12'hA77, "R12 write under override");

    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule